// File: doc/BRIEF.md
# Block-Copy RAM

A 64-word by 8-bit single-port synchronous RAM with a built-in block-copy engine. When the engine is idle, the RAM is an ordinary memory: a write enable, an address and a data-in bus write one word per clock. A read returns the addressed word on the output one clock later.

To copy a block, the surrounding logic first loads three counters from the low six bits of the data-in bus, each through its own load strobe. The counters hold the word count, the source address and the destination address. A start pulse then hands the RAM to a three-state controller. For each word, the controller spends one cycle reading at the source counter, which advances the source and lowers the count. It spends the next cycle writing the registered read data at the destination counter, which advances the destination. The busy output stays high for the whole copy.

Top module: `blkcopy_ram`

## Requirements
- R1: While idle, a write with `wr_en_ext` high stores `din_ext` at `addr_ext` on the clock edge. The word at `addr_ext` appears on `dout` after the next edge, and a write appears there in a later read.
- R2: A `copy_go` sampled while idle with a nonzero word count N raises `busy` at that edge. `busy` stays high for exactly 2·N cycles and then falls.
- R3: A copy of N words performs, in ascending order i = 0..N-1, mem[(dst+i) mod 64] = mem[(src+i) mod 64]. Each step sees the result of the steps before it, and both addresses wrap past 63 to 0.
- R4: Each word takes a read cycle followed by a write cycle. After a write, the controller returns to reading unless the word count has reached zero, in which case it goes idle.
- R5: `ld_count`, `ld_src` and `ld_dst` each load their own counter from `din_ext[5:0]`. The upper data bits are ignored.
- R6: While `busy` is high, the three load strobes and `copy_go` have no effect on the copy in progress.
- R7: A `copy_go` sampled while idle with a word count of zero raises `busy` for exactly one cycle and leaves the memory unchanged.
- R8: Synchronous active-high `rst` puts the controller in idle with `busy` low and clears all three counters. The memory contents are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_ext | input | 1 | External write enable |
| addr_ext | input | 6 | External address |
| din_ext | input | 8 | External write data; low 6 bits also feed the counter loads |
| ld_count | input | 1 | Load word-count counter |
| ld_src | input | 1 | Load source-address counter |
| ld_dst | input | 1 | Load destination-address counter |
| copy_go | input | 1 | Start a block copy |
| dout | output | 8 | Registered read data |
| busy | output | 1 | Copy in progress |

## Verification
The hardest case to reach from the ports is a control input arriving in the middle of a copy. Load strobes that land between a read cycle and a write cycle must leave the count and both addresses untouched. The bench drives all three strobes with a conflicting value partway through a copy. It then checks that the busy length and the final memory image still match the originally loaded values. The sweep also checks that reset clears the source counter: after a reset, it loads only the count and the destination, then confirms that the copy starts from address 0.

// File: rtl/blkcopy_pkg.sv
`timescale 1ns/1ps
package blkcopy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } ctrl_st_e;

    typedef enum logic [1:0] {
        ASEL_EXT = 2'd0,
        ASEL_SRC = 2'd1,
        ASEL_DST = 2'd2
    } addr_sel_e;

    typedef enum logic {
        DSEL_EXT  = 1'b0,
        DSEL_LOOP = 1'b1
    } data_sel_e;

    typedef struct packed {
        ctrl_st_e st;
        logic     busy;
    } ctrl_reg_t;

endpackage

// File: rtl/blkcopy_counter.sv
`timescale 1ns/1ps
module blkcopy_counter #(
    parameter int W        = 6,
    parameter bit COUNT_UP = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         ce,
    output logic [W-1:0] val
);
    logic [W-1:0] val_d, val_q, step_w;

    generate
        if (COUNT_UP) begin : g_up
            assign step_w = val_q + W'(1);
        end else begin : g_down
            assign step_w = val_q - W'(1);
        end
    endgenerate

    always_comb begin
        val_d = val_q;
        if (ld) begin
            val_d = ld_val;
        end else if (ce) begin
            val_d = step_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign val = val_q;
endmodule

// File: rtl/blkcopy_mem.sv
`timescale 1ns/1ps
module blkcopy_mem #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    // Read-before-write: a read in the same cycle as a write returns the old word.
    always_ff @(posedge clk) begin
        rdata_q <= mem_q[addr];
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/blkcopy_ctrl.sv
`timescale 1ns/1ps
module blkcopy_ctrl
    import blkcopy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      cnt_zero,
    output ctrl_st_e  st,
    output logic      busy,
    output addr_sel_e addr_sel,
    output data_sel_e data_sel,
    output logic      ce_cnt,
    output logic      ce_src,
    output logic      ce_dst,
    output logic      wr_stb
);
    ctrl_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st = cnt_zero ? ST_IDLE : ST_READ;
                end
            end
            ST_READ:  r_d.st = ST_WRITE;
            ST_WRITE: r_d.st = cnt_zero ? ST_IDLE : ST_READ;
            default:  r_d.st = ST_IDLE;
        endcase
        r_d.busy = (r_d.st != ST_IDLE) || ((r_q.st == ST_IDLE) && start && cnt_zero);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, busy: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        addr_sel = ASEL_EXT;
        data_sel = DSEL_EXT;
        ce_cnt   = 1'b0;
        ce_src   = 1'b0;
        ce_dst   = 1'b0;
        wr_stb   = 1'b0;
        case (r_q.st)
            ST_READ: begin
                addr_sel = ASEL_SRC;
                data_sel = DSEL_LOOP;
                ce_cnt   = 1'b1;
                ce_src   = 1'b1;
            end
            ST_WRITE: begin
                addr_sel = ASEL_DST;
                data_sel = DSEL_LOOP;
                ce_dst   = 1'b1;
                wr_stb   = 1'b1;
            end
            default: ;
        endcase
    end

    assign st   = r_q.st;
    assign busy = r_q.busy;
endmodule

// File: rtl/blkcopy_ram.sv
`timescale 1ns/1ps
module blkcopy_ram
    import blkcopy_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_ext,
    input  logic [ADDR_W-1:0] addr_ext,
    input  logic [DATA_W-1:0] din_ext,
    input  logic              ld_count,
    input  logic              ld_src,
    input  logic              ld_dst,
    input  logic              copy_go,
    output logic [DATA_W-1:0] dout,
    output logic              busy
);
    ctrl_st_e          st;
    addr_sel_e         addr_sel;
    data_sel_e         data_sel;
    logic              ce_cnt, ce_src, ce_dst, wr_stb;
    logic              busy_w;
    logic [ADDR_W-1:0] cnt_val, src_val, dst_val;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata, ram_rdata;
    logic              ram_we;
    logic              ld_ok;
    logic [ADDR_W-1:0] ld_val;

    assign ld_ok  = ~busy_w;
    assign ld_val = din_ext[ADDR_W-1:0];

    blkcopy_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (copy_go),
        .cnt_zero (cnt_val == '0),
        .st       (st),
        .busy     (busy_w),
        .addr_sel (addr_sel),
        .data_sel (data_sel),
        .ce_cnt   (ce_cnt),
        .ce_src   (ce_src),
        .ce_dst   (ce_dst),
        .wr_stb   (wr_stb)
    );

    blkcopy_counter #(.W(ADDR_W), .COUNT_UP(1'b0)) u_cnt (
        .clk(clk), .rst(rst), .ld(ld_count & ld_ok), .ld_val(ld_val), .ce(ce_cnt), .val(cnt_val)
    );
    blkcopy_counter #(.W(ADDR_W), .COUNT_UP(1'b1)) u_src (
        .clk(clk), .rst(rst), .ld(ld_src & ld_ok), .ld_val(ld_val), .ce(ce_src), .val(src_val)
    );
    blkcopy_counter #(.W(ADDR_W), .COUNT_UP(1'b1)) u_dst (
        .clk(clk), .rst(rst), .ld(ld_dst & ld_ok), .ld_val(ld_val), .ce(ce_dst), .val(dst_val)
    );

    always_comb begin
        case (addr_sel)
            ASEL_SRC: ram_addr = src_val;
            ASEL_DST: ram_addr = dst_val;
            default:  ram_addr = addr_ext;
        endcase
    end

    assign ram_wdata = (data_sel == DSEL_LOOP) ? ram_rdata : din_ext;
    assign ram_we    = wr_en_ext | wr_stb;

    blkcopy_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    assign dout = ram_rdata;
    assign busy = busy_w;
endmodule

// File: rtl/blkcopy_ram_chk.sv
`timescale 1ns/1ps
module blkcopy_ram_chk
    import blkcopy_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          copy_go,
    input logic          busy,
    input ctrl_st_e      st,
    input logic [AW-1:0] cnt,
    input logic [AW-1:0] src,
    input logic [AW-1:0] dst,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    a_r2_busy_on_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && copy_go && cnt != '0) |=> (busy && st == ST_READ));

    a_r2_busy_drops_at_end: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRITE && cnt == '0) |=> (st == ST_IDLE && !busy));

    a_r4_read_then_write: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READ) |=> (st == ST_WRITE));

    a_r4_write_loops: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRITE && cnt != '0) |=> (st == ST_READ));

    a_r3_read_steps: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READ) |=> (src == $past(src) + ONE && cnt == $past(cnt) - ONE));

    a_r3_write_at_dst: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRITE) |-> (ram_we && ram_addr == dst));

    a_r6_frozen_in_write: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRITE) |=> (cnt == $past(cnt) && src == $past(src)));

    a_r7_zero_pulse: assert property (@(posedge clk) disable iff (rst)
        (!busy && copy_go && cnt == '0) |=> (busy && st == ST_IDLE));
endmodule

bind blkcopy_ram blkcopy_ram_chk #(.AW(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .copy_go  (copy_go),
    .busy     (busy),
    .st       (st),
    .cnt      (cnt_val),
    .src      (src_val),
    .dst      (dst_val),
    .ram_we   (ram_we),
    .ram_addr (ram_addr)
);

// File: tb/test_blkcopy_ram.sv
`timescale 1ns/1ps
module test_blkcopy_ram;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en_ext = 1'b0;
    logic [5:0] addr_ext = '0;
    logic [7:0] din_ext = '0;
    logic       ld_count = 1'b0, ld_src = 1'b0, ld_dst = 1'b0;
    logic       copy_go = 1'b0;
    logic [7:0] dout;
    logic       busy;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] model [64];

    always #4 clk = ~clk;

    blkcopy_ram i_blkcopy_ram (
        .clk(clk), .rst(rst), .wr_en_ext(wr_en_ext), .addr_ext(addr_ext),
        .din_ext(din_ext), .ld_count(ld_count), .ld_src(ld_src), .ld_dst(ld_dst),
        .copy_go(copy_go), .dout(dout), .busy(busy)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        wr_en_ext = 1'b1; addr_ext = 6'(a); din_ext = 8'(d);
        @(negedge clk);
        wr_en_ext = 1'b0;
    endtask

    task automatic rd(int a, output logic [7:0] d);
        addr_ext = 6'(a);
        @(negedge clk);
        d = dout;
    endtask

    task automatic fill(int seed);
        for (int a = 0; a < 64; a++) begin
            model[a] = 8'((a * 37 + seed * 11 + 5) & 255);
            wr(a, model[a]);
        end
    endtask

    task automatic verify(string req, string what);
        logic [7:0] d;
        int bad = 0, first_a = -1, first_d = 0;
        for (int a = 0; a < 64; a++) begin
            rd(a, d);
            if (d !== model[a]) begin
                bad++;
                if (first_a < 0) begin first_a = a; first_d = d; end
            end
        end
        check(bad == 0, req, what, first_d, (first_a < 0) ? 0 : model[first_a]);
    endtask

    task automatic load(int which, int v);
        din_ext = 8'(v);
        ld_count = (which == 0); ld_src = (which == 1); ld_dst = (which == 2);
        @(negedge clk);
        ld_count = 1'b0; ld_src = 1'b0; ld_dst = 1'b0;
    endtask

    // Starts a copy and returns the number of cycles busy stayed high.
    task automatic go(bit poke, output int cyc);
        copy_go = 1'b1;
        @(negedge clk);
        copy_go = 1'b0;
        cyc = 0;
        while (busy && cyc < 300) begin
            if (poke && cyc == 3) begin
                ld_count = 1'b1; ld_src = 1'b1; ld_dst = 1'b1; copy_go = 1'b1;
                din_ext = 8'd50;
            end
            @(negedge clk);
            ld_count = 1'b0; ld_src = 1'b0; ld_dst = 1'b0; copy_go = 1'b0;
            cyc++;
        end
    endtask

    task automatic model_copy(int n, int s, int d);
        for (int i = 0; i < n; i++) model[(d + i) % 64] = model[(s + i) % 64];
    endtask

    // Loads the upper data bits with junk so only bits [5:0] must count (R5).
    task automatic copy(int n, int s, int d, bit poke, string tag);
        int cyc;
        load(0, 8'hC0 | n);
        load(1, 8'h80 | s);
        load(2, 8'h40 | d);
        go(poke, cyc);
        check(cyc == 2 * n, "R2", {tag, " busy length"}, cyc, 2 * n);
        model_copy(n, s, d);
        verify("R3", {tag, " memory image"});
    endtask

    initial begin
        int cyc;
        logic [7:0] d;
        @(negedge clk); @(negedge clk);
        check(busy == 1'b0, "R8", "busy during reset", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R8", "busy after reset", busy, 0);

        // R1: normal write and registered read
        fill(1);
        verify("R1", "initial fill readback");
        wr(9, 8'hA5);
        rd(9, d);
        check(d == 8'hA5, "R1", "overwrite then read", d, 8'hA5);
        model[9] = 8'hA5;

        // R8: reset clears counters, keeps memory
        load(0, 12); load(1, 7); load(2, 33);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        go(1'b0, cyc);
        check(cyc == 1, "R8", "count cleared by reset (one-cycle busy)", cyc, 1);
        verify("R8", "memory kept across reset");
        load(0, 4); load(2, 30);
        go(1'b0, cyc);
        check(cyc == 8, "R8", "busy length src-from-zero copy", cyc, 8);
        model_copy(4, 0, 30);
        verify("R8", "source counter cleared by reset");

        // R7: zero count pulses busy and changes nothing
        load(0, 8'hC0);
        go(1'b0, cyc);
        check(cyc == 1, "R7", "zero-count busy pulse", cyc, 1);
        verify("R7", "memory unchanged after zero-count start");

        // R3/R4: sweep of lengths, sources and destinations
        for (int n = 1; n <= 12; n++) begin
            fill(n + 3);
            copy(n, (n * 5) % 64, (n * 7 + 30) % 64, 1'b0, "R4 sweep");
        end
        fill(20); copy(10, 58, 20, 1'b0, "R3 source wrap");
        fill(21); copy(9, 10, 59, 1'b0, "R3 destination wrap");
        fill(22); copy(8, 4, 6, 1'b0, "R3 forward overlap");
        fill(23); copy(63, 0, 0, 1'b0, "R2 longest self copy");

        // R6: loads and start during a copy are ignored
        fill(24); copy(6, 12, 44, 1'b1, "R6 loads while busy");

        // R5: each strobe loads only its own counter
        fill(25);
        load(0, 3); load(1, 40); load(2, 2);
        load(1, 8'hFF & ~8'h3F | 6'd50);
        go(1'b0, cyc);
        check(cyc == 6, "R5", "count kept when source reloaded", cyc, 6);
        model_copy(3, 50, 2);
        verify("R5", "reloaded source used, destination kept");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule